// File: doc/BRIEF.md
# Per-Root-Complex MSI Capture Controller

This block sits on the inbound memory-write path of one PCIe root complex. Each write is checked against a programmable message-signalled-interrupt target address. A write that lands in that four-byte window is taken out of the stream. Its data selects one of 64 interrupt status bits, and the block sets that bit if its enable is on. Every other write goes on to the memory-side port one cycle later, with its address and data unchanged.

Each root complex gets its own copy of the block. Several root complexes can be set to the same target address, and a message still only affects the status and the interrupt line of the copy that received it. Software reaches the enable and status words, and the target address, over a simple register bus. The block drives a registered level interrupt. That line stays high while any enabled status bit is set.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset, both enable words and both status words read 0, `irq` is 0, `out_valid` is 0, and the target address reads 0x1E77005C.
- R2: An inbound write whose address bits [31:2] equal target bits [31:2] is consumed: `out_valid` stays 0 in the following cycle.
- R3: Any other inbound write appears on `out_valid`/`out_addr`/`out_data` exactly one cycle later, with its address and data unchanged.
- R4: A consumed write sets status bit `in_data[5:0]` (bits 0-31 in the low status word, bits 32-63 in the high word), and the new value is readable after the next clock edge.
- R5: A consumed write does not set a status bit whose enable bit was 0 in the cycle of the write.
- R6: Writing a status word clears each bit written with 1 and leaves the bits written with 0 unchanged.
- R7: `irq` is the OR over all bits of (status AND enable), registered. It updates on the same edge as the state that causes the change, so it stays high until every enabled status bit is clear.
- R8: When a capture and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R9: Writing register index 0 reprograms the target address. After that, writes to the old address are forwarded, and writes to the new address are captured.
- R10: Register indices on `reg_idx`: 0 is the target address, 1 and 2 are the low and high enable words, and 3 and 4 are the low and high status words. Indices 5 to 7 read 0 and ignore writes. `reg_rdata` follows `reg_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inbound write present |
| in_addr | input | 32 | Inbound write address |
| in_data | input | 32 | Inbound write data |
| out_valid | output | 1 | Forwarded write present |
| out_addr | output | 32 | Forwarded write address |
| out_data | output | 32 | Forwarded write data |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Level interrupt |

## Verification
A wrong stored target address shows up in the very next cycle. Either a write that should have been forwarded is swallowed, or a message leaks through to `out_valid`. A status or enable bit that is set or cleared wrongly shows on `irq` on the edge right after the offending write, and on the status word read back over the register bus in the same cycle. A bad merge of capture and clear (R8) is visible only through that read-back. For this reason the bench reads all eight register indices after every stimulus cycle.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
    localparam int NVEC  = 64;
    localparam int SEL_W = $clog2(NVEC);
    localparam int WORD  = 32;

    typedef enum logic [2:0] {
        RI_TARGET = 3'd0,
        RI_EN_LO  = 3'd1,
        RI_EN_HI  = 3'd2,
        RI_ST_LO  = 3'd3,
        RI_ST_HI  = 3'd4
    } reg_idx_e;
endpackage

// File: rtl/msi_addr_match.sv
module msi_addr_match #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] target_i,
    output logic          hit_o
);
    // word-granular compare: byte offset inside the window is ignored
    assign hit_o = (addr_i[AW-1:2] == target_i[AW-1:2]);
endmodule

// File: rtl/msi_vec_decode.sv
module msi_vec_decode #(
    parameter int NV = 64,
    localparam int SW = $clog2(NV)
) (
    input  logic          fire_i,
    input  logic [SW-1:0] sel_i,
    input  logic [NV-1:0] en_i,
    output logic [NV-1:0] set_o
);
    for (genvar g = 0; g < NV; g++) begin : g_bit
        assign set_o[g] = fire_i && (sel_i == SW'(g)) && en_i[g];
    end
endmodule

// File: rtl/msi_fwd_stage.sv
module msi_fwd_stage #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic          drop_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output logic          valid_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } fwd_t;

    fwd_t f_d, f_q;

    always_comb begin
        f_d      = f_q;
        f_d.vld  = valid_i && !drop_i;
        if (valid_i && !drop_i) begin
            f_d.addr = addr_i;
            f_d.data = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign valid_o = f_q.vld;
    assign addr_o  = f_q.addr;
    assign data_o  = f_q.data;
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
    import msi_cap_pkg::*;
#(
    parameter int            AW         = 32,
    parameter int            DW         = 32,
    parameter logic [AW-1:0] TARGET_RST = AW'(32'h1E77_005C)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data,
    input  logic          reg_wr,
    input  logic [2:0]    reg_idx,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          irq
);
    typedef struct packed {
        logic [NVEC-1:0] en;
        logic [NVEC-1:0] st;
        logic [AW-1:0]   tgt;
        logic            irq;
    } cap_state_t;

    cap_state_t s_d, s_q;
    logic            win_hit;
    logic            consume;
    logic [NVEC-1:0] set_vec;

    msi_addr_match #(.AW(AW)) u_match (
        .addr_i   (in_addr),
        .target_i (s_q.tgt),
        .hit_o    (win_hit)
    );

    assign consume = in_valid && win_hit;

    msi_vec_decode #(.NV(NVEC)) u_dec (
        .fire_i (consume),
        .sel_i  (in_data[SEL_W-1:0]),
        .en_i   (s_q.en),
        .set_o  (set_vec)
    );

    msi_fwd_stage #(.AW(AW), .DW(DW)) u_fwd (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (in_valid),
        .drop_i  (win_hit),
        .addr_i  (in_addr),
        .data_i  (in_data),
        .valid_o (out_valid),
        .addr_o  (out_addr),
        .data_o  (out_data)
    );

    always_comb begin
        s_d = s_q;
        if (reg_wr) begin
            case (reg_idx)
                RI_TARGET: s_d.tgt               = AW'(reg_wdata);
                RI_EN_LO:  s_d.en[WORD-1:0]      = reg_wdata;
                RI_EN_HI:  s_d.en[NVEC-1:WORD]   = reg_wdata;
                RI_ST_LO:  s_d.st[WORD-1:0]      = s_q.st[WORD-1:0] & ~reg_wdata;
                RI_ST_HI:  s_d.st[NVEC-1:WORD]   = s_q.st[NVEC-1:WORD] & ~reg_wdata;
                default:   ;
            endcase
        end
        // capture is merged after the clear so it wins on a collision
        s_d.st  = s_d.st | set_vec;
        s_d.irq = |(s_d.st & s_d.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.tgt <= TARGET_RST;
        end else begin
            s_q     <= s_d;
        end
    end

    always_comb begin
        case (reg_idx)
            RI_TARGET: reg_rdata = 32'(s_q.tgt);
            RI_EN_LO:  reg_rdata = s_q.en[WORD-1:0];
            RI_EN_HI:  reg_rdata = s_q.en[NVEC-1:WORD];
            RI_ST_LO:  reg_rdata = s_q.st[WORD-1:0];
            RI_ST_HI:  reg_rdata = s_q.st[NVEC-1:WORD];
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = s_q.irq;

    logic [NVEC-1:0] en_vis, st_vis;
    logic [AW-1:0]   tgt_vis;
    assign en_vis  = s_q.en;
    assign st_vis  = s_q.st;
    assign tgt_vis = s_q.tgt;
endmodule

// File: rtl/msi_capture_ctrl_chk.sv
module msi_capture_ctrl_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [AW-1:0] in_addr,
    input logic [DW-1:0] in_data,
    input logic          out_valid,
    input logic [AW-1:0] out_addr,
    input logic [DW-1:0] out_data,
    input logic          irq,
    input logic [63:0]   en,
    input logic [63:0]   st,
    input logic [AW-1:0] tgt
);
    logic hit;
    assign hit = in_valid && (in_addr[AW-1:2] == tgt[AW-1:2]);

    assert_consumed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !out_valid);

    assert_forwarded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !hit) |=> (out_valid && out_addr == $past(in_addr)
                                && out_data == $past(in_data)));

    assert_set_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st & ~$past(st)) != 64'd0) |-> $past(hit));

    assert_set_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((st & ~$past(st) & ~$past(en)) == 64'd0));

    assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(st & en)));
endmodule

bind msi_capture_ctrl msi_capture_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_addr   (in_addr),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_addr  (out_addr),
    .out_data  (out_data),
    .irq       (irq),
    .en        (en_vis),
    .st        (st_vis),
    .tgt       (tgt_vis)
);

// File: tb/sim_msi_capture_ctrl.sv
module sim_msi_capture_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0, in_data = '0;
    logic        out_valid;
    logic [31:0] out_addr, out_data;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    always #10 clk = ~clk;

    msi_capture_ctrl u0 (.*);

    int n_run = 0, n_fail = 0;
    logic [63:0] m_en = '0, m_st = '0;
    logic [31:0] m_tgt = 32'h1E77_005C;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mread(logic [2:0] i);
        case (i)
            3'd0: return m_tgt;
            3'd1: return m_en[31:0];
            3'd2: return m_en[63:32];
            3'd3: return m_st[31:0];
            3'd4: return m_st[63:32];
            default: return 32'd0;
        endcase
    endfunction

    task automatic rd(logic [2:0] i, output logic [31:0] v);
        reg_idx = i; #1; v = reg_rdata;
    endtask

    task automatic readall(string tag);
        for (int i = 0; i < 8; i++) begin
            logic [31:0] v;
            rd(3'(i), v);
            chk(i >= 5 ? "R10" : tag, {32'd0, v}, {32'd0, mread(3'(i))});
        end
    endtask

    task automatic step(logic v, logic [31:0] a, logic [31:0] d,
                        logic rw, logic [2:0] ri, logic [31:0] rwd);
        logic hit, exp_irq;
        logic [63:0] n_st, n_en;
        logic [31:0] n_tgt;
        @(negedge clk);
        in_valid = v; in_addr = a; in_data = d;
        reg_wr = rw; reg_idx = ri; reg_wdata = rwd;
        hit = v && (a[31:2] == m_tgt[31:2]);
        n_st = m_st; n_en = m_en; n_tgt = m_tgt;
        if (rw) case (ri)
            3'd0: n_tgt = rwd;
            3'd1: n_en[31:0] = rwd;
            3'd2: n_en[63:32] = rwd;
            3'd3: n_st[31:0] = m_st[31:0] & ~rwd;
            3'd4: n_st[63:32] = m_st[63:32] & ~rwd;
            default: ;
        endcase
        if (hit && m_en[d[5:0]]) n_st[d[5:0]] = 1'b1;
        exp_irq = |(n_st & n_en);
        @(posedge clk); #1;
        in_valid = 1'b0; reg_wr = 1'b0;
        m_st = n_st; m_en = n_en; m_tgt = n_tgt;
        if (hit) chk("R2", {63'd0, out_valid}, 64'd0);
        else begin
            chk("R3", {63'd0, out_valid}, {63'd0, v});
            if (v) chk("R3", {out_addr, out_data}, {a, d});
        end
        chk("R7", {63'd0, irq}, {63'd0, exp_irq});
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", {63'd0, irq}, 64'd0);
        chk("R1", {63'd0, out_valid}, 64'd0);
        readall("R1");
        @(negedge clk); rst_n = 1'b1;
        readall("R1");

        // R5: capture with all enables off
        step(1, 32'h1E77_005C, 32'd5, 0, 0, 0);
        rd(3'd3, v); chk("R5", {32'd0, v}, 64'd0);
        // R4: enable and capture bit 63
        step(0, 0, 0, 1, 3'd1, 32'hFFFF_FFFF);
        step(0, 0, 0, 1, 3'd2, 32'h8000_0000);
        step(1, 32'h1E77_005C, 32'hABCD_003F, 0, 0, 0);
        rd(3'd4, v); chk("R4", {32'd0, v}, 64'h8000_0000);
        // byte offset inside window, data low six bits 5
        step(1, 32'h1E77_005F, 32'h0000_0045, 0, 0, 0);
        rd(3'd3, v); chk("R4", {32'd0, v}, 64'h20);
        // R6/R7: clear bit 63 only, irq still high from bit 5
        step(0, 0, 0, 1, 3'd4, 32'h8000_0000);
        rd(3'd4, v); chk("R6", {32'd0, v}, 64'd0);
        chk("R7", {63'd0, irq}, 64'd1);
        // R8: clear and capture bit 5 together
        step(1, 32'h1E77_005C, 32'd5, 1, 3'd3, 32'h20);
        rd(3'd3, v); chk("R8", {32'd0, v}, 64'h20);
        step(0, 0, 0, 1, 3'd3, 32'h20);
        chk("R7", {63'd0, irq}, 64'd0);
        // R9: move target, old address now forwarded
        step(0, 0, 0, 1, 3'd0, 32'h2000_0000);
        step(1, 32'h1E77_005C, 32'd7, 0, 0, 0);
        chk("R9", {63'd0, out_valid}, 64'd1);
        step(1, 32'h2000_0000, 32'd7, 0, 0, 0);
        rd(3'd3, v); chk("R9", {32'd0, v}, 64'h80);
        // R10: unmapped index write ignored
        step(0, 0, 0, 1, 3'd6, 32'hFFFF_FFFF);
        readall("R10");

        void'($urandom(32'd1234));
        for (int c = 0; c < 3000; c++) begin
            logic        v_in, rw;
            logic [31:0] a, d, rwd;
            logic [2:0]  ri;
            v_in = ($urandom % 4) != 0;
            d    = $urandom;
            a    = ($urandom % 2) ? {m_tgt[31:2], 2'($urandom)} : $urandom;
            rw   = ($urandom % 3) == 0;
            ri   = ($urandom % 32 == 0) ? 3'd0 : 3'(1 + $urandom % 7);
            rwd  = $urandom;
            step(v_in, a, d, rw, ri, rwd);
            readall("R4");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule